// File: doc/BRIEF.md
# Programmable Parallel Port with Strobed Handshake

A bus-attached peripheral with three data ports, two of `DW` bits (A, B) and one split into two halves (C), plus a control register. The processor reaches all four through a two-bit register select under chip select with single-cycle read and write strobes. A single mode-set word picks the direction of each port and port-C half. It also chooses whether port A and port B run in basic mode or in strobed handshake mode. Basic mode offers plain pin access with latched outputs and unlatched inputs.

In strobed mode, the port-C half paired with the port turns into handshake lines. Port A pairs with the upper half and port B with the lower half. A strobed input latches peripheral data on a falling strobe and reports buffer-full. After the strobe rises, it raises an interrupt request. A strobed output signals buffer-full (active low) after a processor write. The peripheral acknowledge releases that signal, and its rising edge raises an interrupt request. A per-port interrupt enable, kept in a port-C latch bit, gates each request.

Top module: `ppi_top`

## Requirements
- R1: Select values are 0 = port A, 1 = port B, 2 = port C and 3 = control. Reading the control register returns the last mode-set word. After reset it reads 8'h9B, which sets every port to basic input.
- R2: A control write with bit 7 = 0 leaves the control register unchanged.
- R3: In basic output mode, a port write appears on the port's output pins at the next cycle with output enable high. A read of the port returns the written value.
- R4: In basic input mode, the port's output enable is low and a read returns the current pin values in the same cycle.
- R5: Mode-word fields are: bit 6..5 group-A mode (00 basic, any other value strobed), bit 4 port A input, bit 3 upper C input, bit 2 port B strobed, bit 1 port B input, bit 0 lower C input. A set input bit means input. Port-C bits outside handshake use follow their half's direction bit. A port-C read returns the pin value for input bits and the driven value for output bits.
- R6: In strobed input mode, a falling strobe latches the port pins and sets buffer-full (high) one cycle later. A port read returns the latched value, not the live pins. The cycle after that read, buffer-full is low.
- R7: In strobed input mode with interrupt enable set, a rising strobe while buffer-full is set drives the interrupt line high. A port read drops it.
- R8: In strobed output mode, a port write drives the data on the port and the next cycle shows buffer-full low and the interrupt low. A falling acknowledge returns buffer-full high. A rising acknowledge then raises the interrupt when enabled.
- R9: The interrupt enable of a strobed port is port-C latch bit (half base + 2). With it clear, the interrupt line stays low.
- R10: A mode-set write clears the port output latches, the port-C latch, both buffer-full flags (output buffer-full returns high) and the interrupt requests.
- R11: The handshake lines sit at half offsets 0 (strobe/acknowledge input), 1 (buffer-full output) and 2 (interrupt output). Port A uses PC4..PC6 and port B uses PC0..PC2. Offset 3 of each half stays general purpose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 2 | Register select |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid while cs_i and rd_i are high |
| pa_i | input | DW | Port A pin input |
| pa_o | output | DW | Port A pin output |
| pa_oe_o | output | DW | Port A output enable |
| pb_i | input | DW | Port B pin input |
| pb_o | output | DW | Port B pin output |
| pb_oe_o | output | DW | Port B output enable |
| pc_i | input | DW | Port C pin input |
| pc_o | output | DW | Port C pin output |
| pc_oe_o | output | DW | Port C output enable |

## Verification
Read data is combinational, so every read is sampled one time unit after the strobes are driven, inside the same cycle. Writes, mode sets and pin edges on the handshake inputs take effect on the next rising edge. The bench drives each stimulus at a falling edge and checks one falling edge later, after exactly one rising edge. Interrupt behaviour is observed at the second edge of a strobe pulse, after the first edge has been checked for buffer-full. Flag clearing on read is checked at the falling edge after the read cycle.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  typedef struct packed {
    logic       set;
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  localparam logic [7:0] CTRL_RST = 8'h9B;
endpackage

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ctrl_i,
  input  logic [7:0] wdata_i,
  output ctrl_t      ctrl_o,
  output logic       mode_set_o
);
  ctrl_t ctrl_q;

  assign mode_set_o = wr_ctrl_i & wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_q <= ctrl_t'(CTRL_RST);
    else if (mode_set_o) ctrl_q <= ctrl_t'(wdata_i);
  end

  assign ctrl_o = ctrl_q;

  a_r2_ctrl_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && !wdata_i[7]) |=> $stable(ctrl_q));
endmodule

// File: rtl/ppi_hs_port.sv
module ppi_hs_port #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          strobed_i,
  input  logic          dir_in_i,
  input  logic          inte_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] pin_i,
  input  logic          hs_i,
  output logic [DW-1:0] pin_o,
  output logic [DW-1:0] oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          bf_o,
  output logic          intr_o
);
  logic [DW-1:0] out_q, in_q;
  logic          ibf_q, obf_nq, req_q, hs_q;
  logic          hs_fall, hs_rise;

  assign hs_fall = hs_q & ~hs_i;
  assign hs_rise = ~hs_q & hs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      in_q   <= '0;
      ibf_q  <= 1'b0;
      obf_nq <= 1'b1;
      req_q  <= 1'b0;
      hs_q   <= 1'b1;
    end else begin
      hs_q <= hs_i;
      if (clear_i) begin
        out_q  <= '0;
        in_q   <= '0;
        ibf_q  <= 1'b0;
        obf_nq <= 1'b1;
        req_q  <= 1'b0;
      end else begin
        if (wr_i) out_q <= wdata_i;
        if (strobed_i && dir_in_i) begin
          // strobe wins over a coincident read
          if (hs_fall) begin
            in_q  <= pin_i;
            ibf_q <= 1'b1;
          end else if (rd_i) begin
            ibf_q <= 1'b0;
          end
          if (hs_rise && ibf_q) req_q <= 1'b1;
          else if (rd_i)        req_q <= 1'b0;
        end else if (strobed_i) begin
          if (wr_i)         obf_nq <= 1'b0;
          else if (hs_fall) obf_nq <= 1'b1;
          if (wr_i)                   req_q <= 1'b0;
          else if (hs_rise && obf_nq) req_q <= 1'b1;
        end
      end
    end
  end

  assign pin_o   = out_q;
  assign oe_o    = {DW{~dir_in_i}};
  assign rdata_o = dir_in_i ? (strobed_i ? in_q : pin_i) : out_q;
  assign bf_o    = dir_in_i ? ibf_q : obf_nq;
  assign intr_o  = strobed_i & inte_i & req_q;

  a_r6_stb_sets_ibf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobed_i && dir_in_i && !clear_i && hs_fall) |=> ibf_q);

  a_r6_read_clears_ibf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobed_i && dir_in_i && !clear_i && rd_i && !hs_fall) |=> !ibf_q && !req_q);

  a_r8_write_drops_obf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobed_i && !dir_in_i && !clear_i && wr_i) |=> !obf_nq && !req_q);

  a_r10_clear_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (out_q == '0) && !ibf_q && obf_nq && !req_q);
endmodule

// File: rtl/ppi_portc_half.sv
module ppi_portc_half #(
  parameter int HW = 4
) (
  input  logic          strobed_i,
  input  logic          half_in_i,
  input  logic [HW-1:0] latch_i,
  input  logic          bf_i,
  input  logic          intr_i,
  output logic [HW-1:0] pin_o,
  output logic [HW-1:0] oe_o
);
  // handshake offsets within a half
  localparam int HS_OFF   = 0;
  localparam int BF_OFF   = 1;
  localparam int INTR_OFF = 2;

  always_comb begin
    pin_o = latch_i;
    oe_o  = {HW{~half_in_i}};
    if (strobed_i) begin
      oe_o[HS_OFF]    = 1'b0;
      oe_o[BF_OFF]    = 1'b1;
      oe_o[INTR_OFF]  = 1'b1;
      pin_o[BF_OFF]   = bf_i;
      pin_o[INTR_OFF] = intr_i;
    end
  end
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o
);
  localparam int HW    = DW / 2;
  localparam int NPORT = 2;

  ctrl_t         ctrl;
  logic          mode_set;
  logic          wr_hit, rd_hit;
  logic [DW-1:0] pc_q, pc_rd;

  logic          strobed [NPORT];
  logic          dir_in  [NPORT];
  logic          half_in [NPORT];
  logic          hs_in   [NPORT];
  logic          inte    [NPORT];
  logic          bf      [NPORT];
  logic          intr    [NPORT];
  logic          p_wr    [NPORT];
  logic          p_rd    [NPORT];
  logic [DW-1:0] p_pin_i [NPORT];
  logic [DW-1:0] p_pin_o [NPORT];
  logic [DW-1:0] p_oe    [NPORT];
  logic [DW-1:0] p_rdata [NPORT];

  assign wr_hit = cs_i & wr_i;
  assign rd_hit = cs_i & rd_i;

  ppi_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_hit && sel_e'(addr_i) == SEL_CTRL),
    .wdata_i    (wdata_i[7:0]),
    .ctrl_o     (ctrl),
    .mode_set_o (mode_set)
  );

  // index 0 = port A / upper C half, index 1 = port B / lower C half
  assign strobed[0] = |ctrl.a_mode;
  assign dir_in[0]  = ctrl.a_in;
  assign half_in[0] = ctrl.cu_in;
  assign strobed[1] = ctrl.b_mode;
  assign dir_in[1]  = ctrl.b_in;
  assign half_in[1] = ctrl.cl_in;
  assign p_pin_i[0] = pa_i;
  assign p_pin_i[1] = pb_i;
  assign p_wr[0]    = wr_hit && sel_e'(addr_i) == SEL_A;
  assign p_wr[1]    = wr_hit && sel_e'(addr_i) == SEL_B;
  assign p_rd[0]    = rd_hit && sel_e'(addr_i) == SEL_A;
  assign p_rd[1]    = rd_hit && sel_e'(addr_i) == SEL_B;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  pc_q <= '0;
    else if (mode_set)                            pc_q <= '0;
    else if (wr_hit && sel_e'(addr_i) == SEL_C)   pc_q <= wdata_i;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_grp
    localparam int BASE = (p == 0) ? HW : 0;

    assign hs_in[p] = pc_i[BASE];
    assign inte[p]  = pc_q[BASE+2];

    ppi_hs_port #(.DW(DW)) u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (mode_set),
      .strobed_i (strobed[p]),
      .dir_in_i  (dir_in[p]),
      .inte_i    (inte[p]),
      .wr_i      (p_wr[p]),
      .rd_i      (p_rd[p]),
      .wdata_i   (wdata_i),
      .pin_i     (p_pin_i[p]),
      .hs_i      (hs_in[p]),
      .pin_o     (p_pin_o[p]),
      .oe_o      (p_oe[p]),
      .rdata_o   (p_rdata[p]),
      .bf_o      (bf[p]),
      .intr_o    (intr[p])
    );

    ppi_portc_half #(.HW(HW)) u_half (
      .strobed_i (strobed[p]),
      .half_in_i (half_in[p]),
      .latch_i   (pc_q[BASE +: HW]),
      .bf_i      (bf[p]),
      .intr_i    (intr[p]),
      .pin_o     (pc_o[BASE +: HW]),
      .oe_o      (pc_oe_o[BASE +: HW])
    );
  end

  assign pa_o    = p_pin_o[0];
  assign pa_oe_o = p_oe[0];
  assign pb_o    = p_pin_o[1];
  assign pb_oe_o = p_oe[1];
  assign pc_rd   = (pc_oe_o & pc_o) | (~pc_oe_o & pc_i);

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      unique case (sel_e'(addr_i))
        SEL_A:    rdata_o = p_rdata[0];
        SEL_B:    rdata_o = p_rdata[1];
        SEL_C:    rdata_o = pc_rd;
        SEL_CTRL: rdata_o = DW'(ctrl);
      endcase
    end
  end

  a_r9_intr_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobed[1] && !pc_q[2]) |-> !pc_o[2]);
endmodule

// File: tb/ppi_top_tb.sv
module ppi_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [1:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [DW-1:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [DW-1:0] pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  ppi_top #(.DW(DW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe_o),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  // expected port-C output enables from a mode word (R5, R11)
  function automatic logic [7:0] exp_pc_oe(input logic [7:0] cw);
    logic [7:0] r;
    r[7:4] = cw[3] ? 4'h0 : 4'hF;
    r[3:0] = cw[0] ? 4'h0 : 4'hF;
    if (cw[6:5] != 2'b00) r[6:4] = 3'b110;
    if (cw[2])            r[2:0] = 3'b110;
    return r;
  endfunction

  function automatic logic [7:0] exp_pc_rd(input logic [7:0] oe, input logic [7:0] lat,
                                           input logic [7:0] pins);
    return (oe & lat) | (~oe & pins);
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, x, y, z, cw;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();

    // R1 reset state
    bus_rd(2'd3, d);            check("R1 reset ctrl", d, 8'h9B);
    check("R4 reset pa_oe", pa_oe_o, 8'h00);
    check("R5 reset pc_oe", pc_oe_o, 8'h00);

    // R2 word without bit 7
    bus_wr(2'd3, 8'h05);
    bus_rd(2'd3, d);            check("R2 ctrl unchanged", d, 8'h9B);

    // R3 / R5 basic output, random data
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd3, d);            check("R1 ctrl readback", d, 8'h80);
    for (int i = 0; i < 8; i++) begin
      x = 8'($urandom); y = 8'($urandom); z = 8'($urandom);
      bus_wr(2'd0, x); bus_wr(2'd1, y); bus_wr(2'd2, z);
      check("R3 pa_o", pa_o, x);  check("R3 pa_oe", pa_oe_o, 8'hFF);
      check("R3 pb_o", pb_o, y);
      check("R5 pc_o", pc_o, z);  check("R5 pc_oe", pc_oe_o, 8'hFF);
      bus_rd(2'd0, d);            check("R3 read A", d, x);
      bus_rd(2'd1, d);            check("R3 read B", d, y);
    end

    // R10 mode set clears latches
    bus_wr(2'd3, 8'h80);
    check("R10 pa_o cleared", pa_o, 8'h00);
    check("R10 pb_o cleared", pb_o, 8'h00);
    check("R10 pc_o cleared", pc_o, 8'h00);

    // R4 / R5 basic input, random pins
    bus_wr(2'd3, 8'h9B);
    for (int i = 0; i < 6; i++) begin
      x = 8'($urandom); y = 8'($urandom); z = 8'($urandom);
      step(); pa_i = x; pb_i = y; pc_i = z;
      bus_rd(2'd0, d); check("R4 read A pins", d, x);
      bus_rd(2'd1, d); check("R4 read B pins", d, y);
      bus_rd(2'd2, d); check("R5 read C pins", d, z);
    end
    check("R4 pb_oe", pb_oe_o, 8'h00);

    // R5 mixed port-C halves: upper input, lower output
    bus_wr(2'd3, 8'h88);
    check("R5 pc_oe mixed", pc_oe_o, exp_pc_oe(8'h88));
    for (int i = 0; i < 4; i++) begin
      x = 8'($urandom); z = 8'($urandom);
      bus_wr(2'd2, x); pc_i = z;
      bus_rd(2'd2, d); check("R5 read C mixed", d, exp_pc_rd(exp_pc_oe(8'h88), x, z));
    end

    // R11 example word: B strobed out, lower C in, A basic in, upper C out
    pc_i = 8'h01;
    bus_wr(2'd3, 8'h95);
    check("R11 pc_oe for 95", pc_oe_o, exp_pc_oe(8'h95));
    check("R11 pb_oe strobed out", pb_oe_o, 8'hFF);
    check("R11 pa_oe basic in", pa_oe_o, 8'h00);

    // R6 / R7 strobed input on port A, upper half
    pc_i = 8'h10;
    cw = 8'hB0;
    bus_wr(2'd3, cw);
    check("R11 pc_oe strobed A", pc_oe_o, exp_pc_oe(cw));
    bus_wr(2'd2, 8'h40);        // R9 enable A
    check("R6 ibf idle", {7'd0, pc_o[5]}, 8'h00);
    x = 8'($urandom);
    pa_i = x;
    step(); pc_i[4] = 1'b0; step();
    check("R6 ibf set", {7'd0, pc_o[5]}, 8'h01);
    check("R7 no intr while low", {7'd0, pc_o[6]}, 8'h00);
    pa_i = ~x;
    pc_i[4] = 1'b1; step();
    check("R7 intr after rise", {7'd0, pc_o[6]}, 8'h01);
    bus_rd(2'd0, d);            check("R6 read latched A", d, x);
    check("R6 ibf cleared", {7'd0, pc_o[5]}, 8'h00);
    check("R7 intr cleared", {7'd0, pc_o[6]}, 8'h00);

    // R9 enable off
    bus_wr(2'd2, 8'h00);
    pc_i[4] = 1'b0; step(); pc_i[4] = 1'b1; step();
    check("R9 ibf set no enable", {7'd0, pc_o[5]}, 8'h01);
    check("R9 intr held low", {7'd0, pc_o[6]}, 8'h00);

    // R8 strobed output on port B, lower half
    pc_i = 8'h01;
    cw = 8'h84;
    bus_wr(2'd3, cw);
    check("R10 obf high after mode set", {7'd0, pc_o[1]}, 8'h01);
    check("R11 pc_oe strobed B", pc_oe_o, exp_pc_oe(cw));
    bus_wr(2'd2, 8'h04);
    y = 8'($urandom);
    bus_wr(2'd1, y);
    check("R8 data on pb", pb_o, y);
    check("R8 obf low", {7'd0, pc_o[1]}, 8'h00);
    check("R8 intr low", {7'd0, pc_o[2]}, 8'h00);
    step(); pc_i[0] = 1'b0; step();
    check("R8 obf released", {7'd0, pc_o[1]}, 8'h01);
    check("R8 intr still low", {7'd0, pc_o[2]}, 8'h00);
    pc_i[0] = 1'b1; step();
    check("R8 intr after ack", {7'd0, pc_o[2]}, 8'h01);
    bus_wr(2'd1, ~y);
    check("R8 intr cleared by write", {7'd0, pc_o[2]}, 8'h00);
    check("R8 obf low again", {7'd0, pc_o[1]}, 8'h00);
    bus_wr(2'd3, cw);
    check("R10 obf cleared", {7'd0, pc_o[1]}, 8'h01);
    check("R10 pb cleared", pb_o, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule